// File: doc/BRIEF.md
# Write Buffer with Read Bypass

This block sits between a data cache and the next memory level. It takes whole-block writes from the cache (dirty lines being evicted, or write-through traffic gathered into blocks) and holds them in a small queue. The processor therefore does not stall while memory is busy. Queued writes go to memory in the order they arrived, one per memory handshake.

A read miss from the cache is compared against every queued write address at block granularity. If no queued write matches, the read goes to memory ahead of the writes that are still queued. If one or more entries match, the newest matching entry answers the read, and memory is not involved. A parameter selects a simpler policy instead: the read waits until the queue is empty and is then sent to memory, with no comparison at all.

All data-carrying interfaces use valid/ready. A transfer happens on a rising clock edge where both valid and ready are high. Once a sender raises valid, it keeps valid high and its payload stable until the transfer happens. The memory response has no ready: the block has at most one read outstanding and always takes the response.

Top module: `wrbuf_bypass`

## Requirements
- R1: `wr_ready` is low exactly when DEPTH entries (default 4) are held. A write is taken only on a cycle where `wr_valid` and `wr_ready` are both high, and it is held while ready stays low.
- R2: Queued writes leave through the memory port with `mem_req_we`=1, oldest first, one entry per accepted request, carrying that entry's block address and data. No write request is made when the queue is empty.
- R3: In bypass mode (WAIT_EMPTY=0), a read miss matching no queued address is sent to memory (`mem_req_we`=0) before any write still queued. The only exception is a write already offered and not yet accepted, which completes first. The response is the word taken from the memory block.
- R4: In bypass mode, a read miss matching one or more queued addresses is answered from the newest matching entry, with no memory request. A write taken in the same cycle as the read counts as younger than the read.
- R5: The returned word is word `rd_word` of the block: word k lies at bits [k*DW +: DW] of the block data, on both the memory path and the forwarding path.
- R6: With WAIT_EMPTY=1, no data is forwarded. A read miss is held until the queue is empty and is then sent to memory, so it reaches memory after every write that was queued before it.
- R7: One read at a time: `rd_ready` is low from the cycle after a read is taken until its response has been taken.
- R8: `mem_req_valid` and `rd_rsp_valid` follow valid/ready. Once raised and not yet accepted, valid stays high and the payload stays unchanged on the next cycle.
- R9: After reset, `wr_ready` and `rd_ready` are high, and `mem_req_valid` and `rd_rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Cache offers a block write |
| wr_ready | output | 1 | Queue has room |
| wr_addr | input | AW | Block address of the write |
| wr_data | input | DW*WORDS | Block data of the write |
| rd_valid | input | 1 | Cache offers a read miss |
| rd_ready | output | 1 | Read miss can be taken |
| rd_addr | input | AW | Block address of the read miss |
| rd_word | input | clog2(WORDS) | Word select within the block |
| rd_rsp_valid | output | 1 | Read data is available |
| rd_rsp_ready | input | 1 | Cache takes the read data |
| rd_rsp_data | output | DW | Selected word |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Block address of the request |
| mem_req_wdata | output | DW*WORDS | Block data for a write request |
| mem_rsp_valid | input | 1 | Memory returns read data (one cycle, no back-pressure) |
| mem_rsp_data | input | DW*WORDS | Block returned by memory |

## Verification
A wrong occupancy count shows at `wr_ready` in the same cycle: the port either refuses a write while there is room, or accepts one that overwrites the oldest entry. A broken read or write pointer shows at the next accepted memory write, as a wrong address or a repeated block. A bad match decision appears one cycle after the read is taken. It shows either as a stale word from the forwarding path, or as a read that reaches memory ahead of (or behind) the wrong writes in the memory request sequence. A corrupted word select appears as the wrong byte group in `rd_rsp_data` in the response cycle itself.

// File: rtl/wrbuf_pkg.sv
package wrbuf_pkg;

  // Read-miss sequencer states
  typedef enum logic [2:0] {
    RD_IDLE,   // ready for a new read miss
    RD_HOLD,   // wait-empty policy: queue still draining
    RD_ISSUE,  // read request offered to memory
    RD_MEM,    // waiting for the memory block
    RD_RESP    // word held for the cache
  } rd_state_e;

endpackage

// File: rtl/wrbuf_store.sv
module wrbuf_store #(
  parameter int DEPTH = 4,
  parameter int AW    = 26,
  parameter int BW    = 128,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push,
  input  logic [AW-1:0]                 push_addr,
  input  logic [BW-1:0]                 push_data,
  input  logic                          pop,
  output logic [PTR_W-1:0]              head_ptr,
  output logic [CNT_W-1:0]              count,
  output logic [DEPTH-1:0][AW-1:0]      slot_addr,
  output logic [DEPTH-1:0][BW-1:0]      slot_data
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] tail_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_ptr <= '0;
      tail_ptr <= '0;
      count    <= '0;
    end else begin
      if (push) tail_ptr <= bump(tail_ptr);
      if (pop)  head_ptr <= bump(head_ptr);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  // Payload storage carries no reset; occupancy guards every read of it.
  always_ff @(posedge clk) begin
    if (push) begin
      slot_addr[tail_ptr] <= push_addr;
      slot_data[tail_ptr] <= push_data;
    end
  end

endmodule

// File: rtl/wrbuf_cam.sv
module wrbuf_cam #(
  parameter int DEPTH = 4,
  parameter int AW    = 26,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0][AW-1:0] slot_addr,
  input  logic [PTR_W-1:0]         head_ptr,
  input  logic [CNT_W-1:0]         count,
  input  logic [AW-1:0]            key,
  output logic                     hit,
  output logic [PTR_W-1:0]         hit_idx
);

  int pos;

  // Scan from oldest to newest; a later match overrides, so the newest wins.
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    pos     = 0;
    for (int i = 0; i < DEPTH; i++) begin
      pos = (int'(head_ptr) + i) % DEPTH;
      if (i < int'(count) && slot_addr[pos] == key) begin
        hit     = 1'b1;
        hit_idx = PTR_W'(pos);
      end
    end
  end

endmodule

// File: rtl/wrbuf_rdctl.sv
module wrbuf_rdctl
  import wrbuf_pkg::*;
#(
  parameter int AW         = 26,
  parameter int DW         = 32,
  parameter int WORDS      = 4,
  parameter bit WAIT_EMPTY = 1'b0,
  localparam int BW    = DW * WORDS,
  localparam int SEL_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_valid,
  output logic             rd_ready,
  input  logic [AW-1:0]    rd_addr,
  input  logic [SEL_W-1:0] rd_word,
  output logic             rd_rsp_valid,
  input  logic             rd_rsp_ready,
  output logic [DW-1:0]    rd_rsp_data,
  input  logic             fwd_hit,
  input  logic [BW-1:0]    fwd_block,
  input  logic             buf_empty,
  output logic             issue_req,
  input  logic             issue_grant,
  output logic [AW-1:0]    issue_addr,
  input  logic             mem_rsp_valid,
  input  logic [BW-1:0]    mem_rsp_data
);

  rd_state_e        st;
  logic [AW-1:0]    addr_q;
  logic [SEL_W-1:0] sel_q;
  logic [DW-1:0]    rsp_q;
  logic             must_wait;

  generate
    if (WAIT_EMPTY) begin : g_wait_policy
      assign must_wait = !buf_empty;
    end else begin : g_bypass_policy
      assign must_wait = 1'b0;
    end
  endgenerate

  assign rd_ready     = (st == RD_IDLE);
  assign rd_rsp_valid = (st == RD_RESP);
  assign rd_rsp_data  = rsp_q;
  assign issue_req    = (st == RD_ISSUE);
  assign issue_addr   = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= RD_IDLE;
      addr_q <= '0;
      sel_q  <= '0;
      rsp_q  <= '0;
    end else begin
      unique case (st)
        RD_IDLE: if (rd_valid) begin
          addr_q <= rd_addr;
          sel_q  <= rd_word;
          if (fwd_hit) begin
            rsp_q <= fwd_block[int'(rd_word)*DW +: DW];
            st    <= RD_RESP;
          end else if (must_wait) begin
            st <= RD_HOLD;
          end else begin
            st <= RD_ISSUE;
          end
        end
        RD_HOLD:  if (!must_wait) st <= RD_ISSUE;
        RD_ISSUE: if (issue_grant) st <= RD_MEM;
        RD_MEM: if (mem_rsp_valid) begin
          rsp_q <= mem_rsp_data[int'(sel_q)*DW +: DW];
          st    <= RD_RESP;
        end
        RD_RESP:  if (rd_rsp_ready) st <= RD_IDLE;
        default:  st <= RD_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wrbuf_bypass.sv
module wrbuf_bypass #(
  parameter int AW         = 26,
  parameter int DW         = 32,
  parameter int WORDS      = 4,
  parameter int DEPTH      = 4,
  parameter bit WAIT_EMPTY = 1'b0,
  localparam int BW    = DW * WORDS,
  localparam int SEL_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [AW-1:0]    wr_addr,
  input  logic [BW-1:0]    wr_data,
  input  logic             rd_valid,
  output logic             rd_ready,
  input  logic [AW-1:0]    rd_addr,
  input  logic [SEL_W-1:0] rd_word,
  output logic             rd_rsp_valid,
  input  logic             rd_rsp_ready,
  output logic [DW-1:0]    rd_rsp_data,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_we,
  output logic [AW-1:0]    mem_req_addr,
  output logic [BW-1:0]    mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic [BW-1:0]    mem_rsp_data
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic                     push, pop, buf_empty;
  logic [PTR_W-1:0]         head_ptr;
  logic [CNT_W-1:0]         count;
  logic [DEPTH-1:0][AW-1:0] slot_addr;
  logic [DEPTH-1:0][BW-1:0] slot_data;
  logic                     fwd_hit;
  logic [PTR_W-1:0]         fwd_idx;
  logic                     issue_req, issue_grant, rd_go;
  logic [AW-1:0]            issue_addr;
  logic                     wr_held;

  assign wr_ready  = (count != CNT_W'(DEPTH));
  assign push      = wr_valid && wr_ready;
  assign buf_empty = (count == '0);

  wrbuf_store #(.DEPTH(DEPTH), .AW(AW), .BW(BW)) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_addr (wr_addr),
    .push_data (wr_data),
    .pop       (pop),
    .head_ptr  (head_ptr),
    .count     (count),
    .slot_addr (slot_addr),
    .slot_data (slot_data)
  );

  generate
    if (WAIT_EMPTY) begin : g_no_compare
      assign fwd_hit = 1'b0;
      assign fwd_idx = '0;
    end else begin : g_compare
      wrbuf_cam #(.DEPTH(DEPTH), .AW(AW)) cam_i (
        .slot_addr (slot_addr),
        .head_ptr  (head_ptr),
        .count     (count),
        .key       (rd_addr),
        .hit       (fwd_hit),
        .hit_idx   (fwd_idx)
      );
    end
  endgenerate

  wrbuf_rdctl #(.AW(AW), .DW(DW), .WORDS(WORDS), .WAIT_EMPTY(WAIT_EMPTY)) rdctl_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_valid      (rd_valid),
    .rd_ready      (rd_ready),
    .rd_addr       (rd_addr),
    .rd_word       (rd_word),
    .rd_rsp_valid  (rd_rsp_valid),
    .rd_rsp_ready  (rd_rsp_ready),
    .rd_rsp_data   (rd_rsp_data),
    .fwd_hit       (fwd_hit),
    .fwd_block     (slot_data[fwd_idx]),
    .buf_empty     (buf_empty),
    .issue_req     (issue_req),
    .issue_grant   (issue_grant),
    .issue_addr    (issue_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data)
  );

  // Memory port arbitration: a waiting read wins, unless a drain write is
  // already on the port and not yet accepted (keeps the valid/ready contract).
  assign rd_go         = issue_req && !wr_held;
  assign mem_req_valid = rd_go || !buf_empty;
  assign mem_req_we    = !rd_go;
  assign mem_req_addr  = rd_go ? issue_addr : slot_addr[head_ptr];
  assign mem_req_wdata = slot_data[head_ptr];
  assign pop           = mem_req_valid && mem_req_ready && mem_req_we;
  assign issue_grant   = rd_go && mem_req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) wr_held <= 1'b0;
    else        wr_held <= mem_req_valid && mem_req_we && !mem_req_ready;
  end

endmodule

// File: rtl/wrbuf_bypass_chk.sv
module wrbuf_bypass_chk #(
  parameter int DEPTH = 4,
  parameter int AW    = 26,
  parameter int DW    = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          rd_ready,
  input logic          rd_rsp_valid,
  input logic          rd_rsp_ready,
  input logic [DW-1:0] rd_rsp_data,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_we,
  input logic [AW-1:0] mem_req_addr
);

  // Occupancy rebuilt from port handshakes only.
  int occ;
  always_ff @(posedge clk) begin
    if (!rst_n) occ <= 0;
    else occ <= occ + ((wr_valid && wr_ready) ? 1 : 0)
                    - ((mem_req_valid && mem_req_ready && mem_req_we) ? 1 : 0);
  end

  a_r1_room_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (occ < DEPTH) |-> wr_ready);

  a_r1_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == DEPTH) |-> !wr_ready);

  a_r2_no_drain_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == 0) |-> !(mem_req_valid && mem_req_we));

  a_r8_mem_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_we) && $stable(mem_req_addr)));

  a_r8_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rsp_valid && !rd_rsp_ready) |=> (rd_rsp_valid && $stable(rd_rsp_data)));

  a_r7_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_valid |-> !rd_ready);

endmodule

bind wrbuf_bypass wrbuf_bypass_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_valid      (wr_valid),
  .wr_ready      (wr_ready),
  .rd_ready      (rd_ready),
  .rd_rsp_valid  (rd_rsp_valid),
  .rd_rsp_ready  (rd_rsp_ready),
  .rd_rsp_data   (rd_rsp_data),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr)
);

// File: tb/wrbuf_tb_mem.sv
module wrbuf_tb_mem (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        stall,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_we,
  input  logic [3:0]  req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_data
);

  logic [31:0] store [16];
  logic        log_we   [64];
  logic [3:0]  log_addr [64];
  int          log_n;
  logic [1:0]  lat;
  logic [31:0] rdq;

  assign req_ready = !stall;
  assign rsp_valid = (lat == 2'd1);
  assign rsp_data  = rdq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < 16; a++)
        for (int k = 0; k < 4; k++)
          store[a][k*8 +: 8] <= {4'(a), 4'(k)};
      lat   <= '0;
      log_n <= 0;
      rdq   <= '0;
    end else begin
      if (req_valid && req_ready) begin
        if (log_n < 64) begin
          log_we[log_n]   <= req_we;
          log_addr[log_n] <= req_addr;
        end
        log_n <= log_n + 1;
        if (req_we) store[req_addr] <= req_wdata;
        else        rdq <= store[req_addr];
      end
      if (req_valid && req_ready && !req_we) lat <= 2'd2;
      else if (lat != 2'd0)                  lat <= lat - 2'd1;
    end
  end

endmodule

// File: tb/wrbuf_bypass_tb_top.sv
module wrbuf_bypass_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        wr_valid [2], wr_ready [2];
  logic [3:0]  wr_addr  [2];
  logic [31:0] wr_data  [2];
  logic        rd_valid [2], rd_ready [2];
  logic [3:0]  rd_addr  [2];
  logic [1:0]  rd_word  [2];
  logic        rd_rsp_valid [2], rd_rsp_ready [2];
  logic [7:0]  rd_rsp_data  [2];
  logic        mq_valid [2], mq_ready [2], mq_we [2];
  logic [3:0]  mq_addr  [2];
  logic [31:0] mq_wdata [2];
  logic        ms_valid [2];
  logic [31:0] ms_data  [2];
  logic        stall    [2];

  logic [31:0] shadow [2][16];
  int nchk = 0;
  int nfail = 0;
  int acc_log;

  wrbuf_bypass #(.AW(4), .DW(8), .WORDS(4), .DEPTH(4), .WAIT_EMPTY(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid[0]), .wr_ready(wr_ready[0]), .wr_addr(wr_addr[0]), .wr_data(wr_data[0]),
    .rd_valid(rd_valid[0]), .rd_ready(rd_ready[0]), .rd_addr(rd_addr[0]), .rd_word(rd_word[0]),
    .rd_rsp_valid(rd_rsp_valid[0]), .rd_rsp_ready(rd_rsp_ready[0]), .rd_rsp_data(rd_rsp_data[0]),
    .mem_req_valid(mq_valid[0]), .mem_req_ready(mq_ready[0]), .mem_req_we(mq_we[0]),
    .mem_req_addr(mq_addr[0]), .mem_req_wdata(mq_wdata[0]),
    .mem_rsp_valid(ms_valid[0]), .mem_rsp_data(ms_data[0]));

  wrbuf_bypass #(.AW(4), .DW(8), .WORDS(4), .DEPTH(4), .WAIT_EMPTY(1'b1)) dut_wait_i (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid[1]), .wr_ready(wr_ready[1]), .wr_addr(wr_addr[1]), .wr_data(wr_data[1]),
    .rd_valid(rd_valid[1]), .rd_ready(rd_ready[1]), .rd_addr(rd_addr[1]), .rd_word(rd_word[1]),
    .rd_rsp_valid(rd_rsp_valid[1]), .rd_rsp_ready(rd_rsp_ready[1]), .rd_rsp_data(rd_rsp_data[1]),
    .mem_req_valid(mq_valid[1]), .mem_req_ready(mq_ready[1]), .mem_req_we(mq_we[1]),
    .mem_req_addr(mq_addr[1]), .mem_req_wdata(mq_wdata[1]),
    .mem_rsp_valid(ms_valid[1]), .mem_rsp_data(ms_data[1]));

  wrbuf_tb_mem mem0 (.clk(clk), .rst_n(rst_n), .stall(stall[0]),
    .req_valid(mq_valid[0]), .req_ready(mq_ready[0]), .req_we(mq_we[0]),
    .req_addr(mq_addr[0]), .req_wdata(mq_wdata[0]),
    .rsp_valid(ms_valid[0]), .rsp_data(ms_data[0]));

  wrbuf_tb_mem mem1 (.clk(clk), .rst_n(rst_n), .stall(stall[1]),
    .req_valid(mq_valid[1]), .req_ready(mq_ready[1]), .req_we(mq_we[1]),
    .req_addr(mq_addr[1]), .req_wdata(mq_wdata[1]),
    .rsp_valid(ms_valid[1]), .rsp_data(ms_data[1]));

  function automatic logic [31:0] init_blk(input int a);
    logic [31:0] b;
    for (int k = 0; k < 4; k++) b[k*8 +: 8] = {4'(a), 4'(k)};
    return b;
  endfunction

  function automatic logic [31:0] wr_blk(input int tag);
    logic [31:0] b;
    for (int k = 0; k < 4; k++) b[k*8 +: 8] = ~{4'(tag), 4'(k)};
    return b;
  endfunction

  function automatic int lg_n(input int u);
    return (u == 0) ? mem0.log_n : mem1.log_n;
  endfunction

  function automatic logic lg_we(input int u, input int i);
    return (u == 0) ? mem0.log_we[i] : mem1.log_we[i];
  endfunction

  function automatic logic [3:0] lg_addr(input int u, input int i);
    return (u == 0) ? mem0.log_addr[i] : mem1.log_addr[i];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input int u, input int a, input int tag);
    wr_valid[u] = 1'b1;
    wr_addr[u]  = 4'(a);
    wr_data[u]  = wr_blk(tag);
    while (!wr_ready[u]) @(negedge clk);
    @(posedge clk);
    shadow[u][a] = wr_blk(tag);
    @(negedge clk);
    wr_valid[u] = 1'b0;
  endtask

  // hold: cycles the response is refused; rel: cycles before stall is lifted
  task automatic do_read(input int u, input int a, input int k, input int hold,
                         input int rel, input string req);
    logic [7:0] exp, first;
    rd_valid[u]     = 1'b1;
    rd_addr[u]      = 4'(a);
    rd_word[u]      = 2'(k);
    rd_rsp_ready[u] = (hold == 0);
    while (!rd_ready[u]) @(negedge clk);
    @(posedge clk);
    exp     = shadow[u][a][k*8 +: 8];
    acc_log = lg_n(u);
    @(negedge clk);
    rd_valid[u] = 1'b0;
    if (rel > 0) begin
      for (int i = 0; i < rel; i++) begin
        check(!rd_rsp_valid[u], {req, " no early response"}, 32'(rd_rsp_valid[u]), 32'd0);
        @(negedge clk);
      end
      stall[u] = 1'b0;
    end
    while (!rd_rsp_valid[u]) @(negedge clk);
    check(rd_rsp_data[u] == exp, req, 32'(rd_rsp_data[u]), 32'(exp));
    first = rd_rsp_data[u];
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(rd_rsp_valid[u] && rd_rsp_data[u] == first, "R8 response held",
            32'(rd_rsp_data[u]), 32'(first));
      check(!rd_ready[u], "R7 no second read", 32'(rd_ready[u]), 32'd0);
    end
    rd_rsp_ready[u] = 1'b1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drain(input int u);
    repeat (2) @(negedge clk);
    while (mq_valid[u]) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int u = 0; u < 2; u++) begin
      wr_valid[u] = 1'b0; wr_addr[u] = '0; wr_data[u] = '0;
      rd_valid[u] = 1'b0; rd_addr[u] = '0; rd_word[u] = '0;
      rd_rsp_ready[u] = 1'b1; stall[u] = 1'b0;
      for (int a = 0; a < 16; a++) shadow[u][a] = init_blk(a);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int u = 0; u < 2; u++) begin
      check(wr_ready[u] && rd_ready[u], "R9 ready after reset", {wr_ready[u], rd_ready[u]}, 32'd3);
      check(!mq_valid[u] && !rd_rsp_valid[u], "R9 idle after reset",
            {mq_valid[u], rd_rsp_valid[u]}, 32'd0);
    end

    // ---------------- bypass unit ----------------
    stall[0] = 1'b1;
    do_write(0, 1, 1); do_write(0, 2, 2); do_write(0, 1, 3); do_write(0, 3, 4);
    for (int i = 0; i < 3; i++) begin
      check(!wr_ready[0], "R1 full back-pressure", 32'(wr_ready[0]), 32'd0);
      @(negedge clk);
    end
    do_read(0, 1, 2, 0, 0, "R4 newest match forwarded");
    do_read(0, 1, 0, 3, 0, "R4 forward with held response");
    do_read(0, 2, 3, 0, 0, "R5 word select on forward");
    do_read(0, 5, 1, 4, 4, "R3 bypass read data");
    check(lg_n(0) >= 2, "R3 request count", 32'(lg_n(0)), 32'd2);
    check(lg_we(0, 0) && lg_addr(0, 0) == 4'd1, "R3 held write first",
          {lg_we(0, 0), lg_addr(0, 0)}, {1'b1, 4'd1});
    check(!lg_we(0, 1) && lg_addr(0, 1) == 4'd5, "R3 read ahead of queued writes",
          {lg_we(0, 1), lg_addr(0, 1)}, {1'b0, 4'd5});
    drain(0);
    check(lg_n(0) == 5, "R2 drain count", 32'(lg_n(0)), 32'd5);
    check(lg_we(0, 2) && lg_addr(0, 2) == 4'd2, "R2 fifo order 2", {lg_we(0, 2), lg_addr(0, 2)}, {1'b1, 4'd2});
    check(lg_we(0, 3) && lg_addr(0, 3) == 4'd1, "R2 fifo order 3", {lg_we(0, 3), lg_addr(0, 3)}, {1'b1, 4'd1});
    check(lg_we(0, 4) && lg_addr(0, 4) == 4'd3, "R2 fifo order 4", {lg_we(0, 4), lg_addr(0, 4)}, {1'b1, 4'd3});
    check(wr_ready[0], "R1 room after drain", 32'(wr_ready[0]), 32'd1);

    // forwarding sweep: each group fills the queue, every word read back
    for (int base = 0; base < 16; base += 4) begin
      stall[0] = 1'b1;
      for (int i = 0; i < 4; i++) do_write(0, base + i, (base + i) ^ 9);
      for (int i = 0; i < 4; i++)
        for (int k = 0; k < 4; k++)
          do_read(0, base + i, k, 0, 0, "R4 R5 forward sweep");
      stall[0] = 1'b0;
      drain(0);
    end
    // memory-path sweep: all blocks, all words
    for (int a = 0; a < 16; a++)
      for (int k = 0; k < 4; k++)
        do_read(0, a, k, 0, 0, "R2 R5 memory sweep");

    // ---------------- wait-empty unit ----------------
    stall[1] = 1'b1;
    do_write(1, 1, 1); do_write(1, 2, 2); do_write(1, 1, 3); do_write(1, 3, 4);
    check(!wr_ready[1], "R1 full back-pressure (wait unit)", 32'(wr_ready[1]), 32'd0);
    do_read(1, 1, 2, 0, 5, "R6 waits, then memory data");
    check(lg_n(1) == 5, "R6 request count", 32'(lg_n(1)), 32'd5);
    for (int i = 0; i < 4; i++)
      check(lg_we(1, i), "R6 writes before read", 32'(lg_we(1, i)), 32'd1);
    check(!lg_we(1, 4) && lg_addr(1, 4) == 4'd1, "R6 read last",
          {lg_we(1, 4), lg_addr(1, 4)}, {1'b0, 4'd1});
    for (int a = 0; a < 16; a++) begin
      do_write(1, a, a + 3);
      do_read(1, a, a % 4, 0, 0, "R6 read after write");
    end
    for (int a = 0; a < 16; a++)
      for (int k = 0; k < 4; k++)
        do_read(1, a, k, 0, 0, "R5 R6 memory sweep");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule